// File: doc/BRIEF.md
# Linked-List DMA Segment Sequencer

The sequencer walks a linked chain of DMA segments and hands each one to a separate transfer engine. A start pulse latches the first segment straight from the configuration inputs. These inputs give the local address, a 64-bit host address, a byte count, a 64-bit next pointer and an attribute word. The sequencer passes that segment to the engine with a one-cycle start strobe and then waits for the engine's done pulse.

When a segment ends, bit 1 of its attribute word decides what happens next. If the bit is set, the sequencer reads a seven-word descriptor from host memory at the next pointer, one 32-bit word at a time. It then makes that descriptor the new current segment and repeats. If the bit is clear, the chain is over, and a completion interrupt level rises and stays up until a clear pulse. An abort pulse stops the chain at any point and leaves the sequencer in an aborted state, which is also left with the clear pulse.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `chainDoneIrq`, `abortedFlag`, `segStart`, `segAbort` and `memReqValid` are all 0.
- R2: A `startReq` pulse in idle captures the `cfg*` inputs as the first segment. Unless its count is zero, `segStart` then pulses high for exactly one cycle, with `segLocalAddr`, `segHostAddr` and `segByteCount` equal to the captured values.
- R3: When a segment ends with attribute bit 1 set, the sequencer issues seven word reads. They go to next pointer + 0, 4, 8, 12, 16, 20 and 24, in that order. Only one read is outstanding at a time, and each `memReqValid` is a single-cycle request that waits for its `memRspValid`.
- R4: The seven fetched words are, in order: local address, host address bits 31:0, host address bits 63:32, byte count, next pointer bits 31:0, next pointer bits 63:32, attribute. Together they become the next segment issued.
- R5: A segment whose attribute bit 1 is clear ends the chain. All other attribute bits are ignored.
- R6: `chainDoneIrq` rises once per chain, only after the last segment ends. It stays high until `clearReq`, and it is low while any earlier segment is issued or fetched.
- R7: A segment with byte count 0 produces no `segStart` and ends at once. The chain continues or completes according to that segment's attribute.
- R8: `abortReq` while a chain runs moves the sequencer to the aborted state. In that state `abortedFlag` is 1, `chainDoneIrq` is 0, and no further segment or read is issued. An abort while the engine is busy also pulses `segAbort` in the same cycle.
- R9: `startReq` while the sequencer is not idle is ignored. The running chain continues unchanged.
- R10: `clearReq` in the completed or aborted state returns the sequencer to idle one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, taken only in idle |
| abortReq | input | 1 | Abort pulse |
| clearReq | input | 1 | Leave completed or aborted state |
| cfgLocalAddr | input | 32 | First segment local address |
| cfgHostAddr | input | 64 | First segment host address |
| cfgByteCount | input | 32 | First segment byte count |
| cfgNextPtr | input | 64 | First segment next descriptor pointer |
| cfgAttr | input | 32 | First segment attribute word |
| memReqValid | output | 1 | Word read request strobe |
| memReqAddr | output | 64 | Word read byte address |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 32 | Read response word |
| segStart | output | 1 | Segment start strobe to engine |
| segAbort | output | 1 | Abort strobe to engine |
| segLocalAddr | output | 32 | Current segment local address |
| segHostAddr | output | 64 | Current segment host address |
| segByteCount | output | 32 | Current segment byte count |
| segDone | input | 1 | Engine segment done strobe |
| busy | output | 1 | Sequencer not idle |
| chainDoneIrq | output | 1 | Chain completion level |
| abortedFlag | output | 1 | Aborted state level |

## Verification
Chains of one to seven segments are built with random addresses, counts and attribute bits, and with random memory and engine latencies. The random addresses and counts tell a correct word order and address step apart from swapped or shifted fields. The random attribute bits show that only bit 1 steers the chain. Directed chains place zero counts in the middle and at the end, and one chain has every count at zero; these separate a skipped segment from an issued one. A start pulse arrives while a chain is running, to show it is ignored. Aborts land during an engine transfer and during a descriptor fetch, and each must give the aborted state with no completion.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    SIdle, SIssue, SWaitDone, SFetch, SLoad, SComplete, SAborted
  } seqState_t;

  typedef struct packed {
    logic loadCfg;
    logic loadDesc;
    logic clrIdx;
    logic latchWord;
  } dpStrobe_t;

  localparam int DescWords = 7;
  localparam int IdxLocal  = 0;
  localparam int IdxHostLo = 1;
  localparam int IdxHostHi = 2;
  localparam int IdxCount  = 3;
  localparam int IdxNextLo = 4;
  localparam int IdxNextHi = 5;
  localparam int IdxAttr   = 6;
endpackage

// File: rtl/dma_chain_dp.sv
module dma_chain_dp
  import dma_chain_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CHAIN_BIT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [WORD_W-1:0]   cfgLocalAddr,
  input  logic [2*WORD_W-1:0] cfgHostAddr,
  input  logic [WORD_W-1:0]   cfgByteCount,
  input  logic [2*WORD_W-1:0] cfgNextPtr,
  input  logic [WORD_W-1:0]   cfgAttr,
  input  logic [WORD_W-1:0]   memRspData,
  output logic [2*WORD_W-1:0] memReqAddr,
  output logic [WORD_W-1:0]   segLocalAddr,
  output logic [2*WORD_W-1:0] segHostAddr,
  output logic [WORD_W-1:0]   segByteCount,
  output logic                countZero,
  output logic                chainFlag,
  output logic                lastWord
);
  localparam int ADDR_W    = 2 * WORD_W;
  localparam int IDX_W     = $clog2(DescWords);
  localparam int BYTE_SHFT = $clog2(WORD_W / 8);

  logic [WORD_W-1:0] curLocal, curCount, curAttr;
  logic [ADDR_W-1:0] curHost, curNext;
  logic [WORD_W-1:0] fetchBuf [DescWords];
  logic [IDX_W-1:0]  wordIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLocal <= '0;
      curHost  <= '0;
      curCount <= '0;
      curNext  <= '0;
      curAttr  <= '0;
    end else if (stb.loadCfg) begin
      curLocal <= cfgLocalAddr;
      curHost  <= cfgHostAddr;
      curCount <= cfgByteCount;
      curNext  <= cfgNextPtr;
      curAttr  <= cfgAttr;
    end else if (stb.loadDesc) begin
      curLocal <= fetchBuf[IdxLocal];
      curHost  <= {fetchBuf[IdxHostHi], fetchBuf[IdxHostLo]};
      curCount <= fetchBuf[IdxCount];
      curNext  <= {fetchBuf[IdxNextHi], fetchBuf[IdxNextLo]};
      curAttr  <= fetchBuf[IdxAttr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrIdx) wordIdx <= '0;
    else if (stb.latchWord)  wordIdx <= wordIdx + 1'b1;
  end

  for (genvar w = 0; w < DescWords; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) fetchBuf[w] <= '0;
      else if (stb.latchWord && wordIdx == IDX_W'(w)) fetchBuf[w] <= memRspData;
    end
  end

  assign memReqAddr   = curNext + (ADDR_W'(wordIdx) << BYTE_SHFT);
  assign segLocalAddr = curLocal;
  assign segHostAddr  = curHost;
  assign segByteCount = curCount;
  assign countZero    = (curCount == '0);
  assign chainFlag    = curAttr[CHAIN_BIT];
  assign lastWord     = (wordIdx == IDX_W'(DescWords - 1));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      abortReq,
  input  logic      clearReq,
  input  logic      segDone,
  input  logic      memRspValid,
  input  logic      countZero,
  input  logic      chainFlag,
  input  logic      lastWord,
  output dpStrobe_t stb,
  output logic      segStart,
  output logic      segAbort,
  output logic      memReqValid,
  output logic      busy,
  output logic      chainDoneIrq,
  output logic      abortedFlag
);
  seqState_t state, nextState;
  logic      pending;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      SIdle: if (startReq) begin
        stb.loadCfg = 1'b1;
        nextState   = SIssue;
      end
      SIssue, SWaitDone: begin
        if (abortReq) nextState = SAborted;
        else if ((state == SIssue && countZero) || (state == SWaitDone && segDone)) begin
          if (chainFlag) begin
            stb.clrIdx = 1'b1;
            nextState  = SFetch;
          end else begin
            nextState  = SComplete;
          end
        end else if (state == SIssue) nextState = SWaitDone;
      end
      SFetch: begin
        if (abortReq) nextState = SAborted;
        else if (pending && memRspValid) begin
          stb.latchWord = 1'b1;
          if (lastWord) nextState = SLoad;
        end
      end
      SLoad: begin
        if (abortReq) nextState = SAborted;
        else begin
          stb.loadDesc = 1'b1;
          nextState    = SIssue;
        end
      end
      SComplete, SAborted: if (clearReq) nextState = SIdle;
      default: nextState = SIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SIdle;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || state != SFetch) pending <= 1'b0;
    else if (memReqValid)         pending <= 1'b1;
    else if (memRspValid)         pending <= 1'b0;
  end

  assign segStart     = (state == SIssue) && !countZero && !abortReq;
  assign segAbort     = (state == SWaitDone) && abortReq;
  assign memReqValid  = (state == SFetch) && !pending && !abortReq;
  assign busy         = (state != SIdle);
  assign chainDoneIrq = (state == SComplete);
  assign abortedFlag  = (state == SAborted);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int CHAIN_BIT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                abortReq,
  input  logic                clearReq,
  input  logic [WORD_W-1:0]   cfgLocalAddr,
  input  logic [2*WORD_W-1:0] cfgHostAddr,
  input  logic [WORD_W-1:0]   cfgByteCount,
  input  logic [2*WORD_W-1:0] cfgNextPtr,
  input  logic [WORD_W-1:0]   cfgAttr,
  output logic                memReqValid,
  output logic [2*WORD_W-1:0] memReqAddr,
  input  logic                memRspValid,
  input  logic [WORD_W-1:0]   memRspData,
  output logic                segStart,
  output logic                segAbort,
  output logic [WORD_W-1:0]   segLocalAddr,
  output logic [2*WORD_W-1:0] segHostAddr,
  output logic [WORD_W-1:0]   segByteCount,
  input  logic                segDone,
  output logic                busy,
  output logic                chainDoneIrq,
  output logic                abortedFlag
);
  dpStrobe_t stb;
  logic      countZero, chainFlag, lastWord;

  dma_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .clearReq(clearReq), .segDone(segDone), .memRspValid(memRspValid),
    .countZero(countZero), .chainFlag(chainFlag), .lastWord(lastWord),
    .stb(stb), .segStart(segStart), .segAbort(segAbort),
    .memReqValid(memReqValid), .busy(busy), .chainDoneIrq(chainDoneIrq),
    .abortedFlag(abortedFlag)
  );

  dma_chain_dp #(.WORD_W(WORD_W), .CHAIN_BIT(CHAIN_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgLocalAddr(cfgLocalAddr), .cfgHostAddr(cfgHostAddr),
    .cfgByteCount(cfgByteCount), .cfgNextPtr(cfgNextPtr), .cfgAttr(cfgAttr),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .segLocalAddr(segLocalAddr), .segHostAddr(segHostAddr),
    .segByteCount(segByteCount), .countZero(countZero),
    .chainFlag(chainFlag), .lastWord(lastWord)
  );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic abortReq,
  input logic clearReq,
  input logic segStart,
  input logic segAbort,
  input logic memReqValid,
  input logic busy,
  input logic chainDoneIrq,
  input logic abortedFlag
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !chainDoneIrq && !abortedFlag && !segStart && !memReqValid && !segAbort);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    segStart |=> !segStart);
  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainDoneIrq |-> !segStart && !memReqValid && !abortedFlag);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainDoneIrq && !clearReq |=> chainDoneIrq);
  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortedFlag && !clearReq |=> abortedFlag && !chainDoneIrq);
  // R8
  abort_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !chainDoneIrq && !abortedFlag && abortReq |=> abortedFlag);
  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !chainDoneIrq && !abortedFlag && startReq && !abortReq |=> busy);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chainDoneIrq || abortedFlag) && clearReq |=> !busy);
endmodule

bind dma_chain_seq dma_chain_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
  .clearReq(clearReq), .segStart(segStart), .segAbort(segAbort),
  .memReqValid(memReqValid), .busy(busy), .chainDoneIrq(chainDoneIrq),
  .abortedFlag(abortedFlag)
);

// File: tb/sim_dma_chain_seq.sv
`timescale 1ns/1ps
module sim_dma_chain_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, abortReq = 0, clearReq = 0;
  logic [31:0] cfgLocalAddr = 0, cfgByteCount = 0, cfgAttr = 0;
  logic [63:0] cfgHostAddr = 0, cfgNextPtr = 0;
  logic memReqValid, memRspValid = 0;
  logic [63:0] memReqAddr;
  logic [31:0] memRspData = 0;
  logic segStart, segAbort, segDone = 0, busy, chainDoneIrq, abortedFlag;
  logic [31:0] segLocalAddr, segByteCount;
  logic [63:0] segHostAddr;

  always #10 clk = ~clk;

  dma_chain_seq u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] hostMem [0:255];
  logic [31:0] expLocal [0:7], expCount [0:7], obsLocal [0:7], obsCount [0:7];
  logic [63:0] expHost [0:7], obsHost [0:7], fetchBase [0:7];
  int nExp, nObs, irqRise, irqAtStart, abortPulses, fetchIdx, wordCnt, rspWait, engWait;
  bit engineHold = 0, prevIrq = 0, fetchSeen = 0;
  logic [63:0] rspAddr;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor, host memory responder and engine model
  always @(negedge clk) begin
    memRspValid <= 1'b0;
    segDone     <= 1'b0;
    if (chainDoneIrq && !prevIrq) irqRise++;
    prevIrq = chainDoneIrq;
    if (segAbort) abortPulses++;
    if (segStart) begin
      if (chainDoneIrq) irqAtStart++;
      if (nObs < 8) begin
        obsLocal[nObs] = segLocalAddr;
        obsHost[nObs]  = segHostAddr;
        obsCount[nObs] = segByteCount;
      end
      nObs++;
      if (!engineHold) engWait = 1 + int'($urandom % 4);
    end else if (engWait > 0) begin
      engWait--;
      if (engWait == 0) segDone <= 1'b1;
    end
    if (memReqValid) begin
      fetchSeen = 1;
      // R3: word address steps by 4 from the next pointer
      chk(memReqAddr == fetchBase[fetchIdx] + 64'(4 * wordCnt), "R3 fetch address",
          memReqAddr, fetchBase[fetchIdx] + 64'(4 * wordCnt));
      wordCnt++;
      if (wordCnt == 7) begin wordCnt = 0; fetchIdx++; end
      rspAddr = memReqAddr;
      rspWait = 1 + int'($urandom % 3);
    end else if (rspWait > 0) begin
      rspWait--;
      if (rspWait == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= hostMem[rspAddr[9:2]];
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic clearMon();
    nExp = 0; nObs = 0; irqRise = 0; irqAtStart = 0; abortPulses = 0;
    fetchIdx = 0; wordCnt = 0; fetchSeen = 0;
  endtask

  // Builds a chain of n segments; zeroMask bit k forces segment k count to 0.
  task automatic buildChain(int n, int zeroMask);
    logic [31:0] nHi, loBase, loc, cnt, attr;
    logic [63:0] host, nxt;
    nHi = $urandom; loBase = $urandom & 32'hFFFF_FC00;
    for (int k = 0; k < n; k++) begin
      loc  = $urandom; host = {$urandom, $urandom};
      cnt  = zeroMask[k] ? 32'h0 : 32'((($urandom % 64) + 1) * 4);
      attr = (k < n - 1) ? ($urandom | 32'h2) : ($urandom & ~32'h2);
      nxt  = (k < n - 1) ? {nHi, loBase | 32'((k + 1) * 32)} : {$urandom, $urandom};
      if (k < n - 1) fetchBase[k] = nxt;
      if (k == 0) begin
        cfgLocalAddr = loc; cfgHostAddr = host; cfgByteCount = cnt;
        cfgNextPtr = nxt; cfgAttr = attr;
      end else begin
        hostMem[k*8 + 0] = loc;         hostMem[k*8 + 1] = host[31:0];
        hostMem[k*8 + 2] = host[63:32]; hostMem[k*8 + 3] = cnt;
        hostMem[k*8 + 4] = nxt[31:0];   hostMem[k*8 + 5] = nxt[63:32];
        hostMem[k*8 + 6] = attr;
      end
      if (cnt != 0) begin
        expLocal[nExp] = loc; expHost[nExp] = host; expCount[nExp] = cnt; nExp++;
      end
    end
  endtask

  task automatic runChain(int n, int zeroMask, bit midStart);
    int t;
    clearMon();
    buildChain(n, zeroMask);
    pulse(startReq);
    if (midStart) begin
      tick(3);
      cfgLocalAddr = $urandom; cfgByteCount = 32'h40; cfgAttr = 0;
      pulse(startReq);
      // R9: late start must not disturb the chain
    end
    t = 0;
    while (!chainDoneIrq && t < 4000) begin tick(1); t++; end
    tick(3);
    chk(chainDoneIrq == 1'b1, "R6 irq raised after last segment", 64'(chainDoneIrq), 1);
    chk(irqRise == 1, "R6 irq rises once", 64'(irqRise), 1);
    chk(irqAtStart == 0, "R6 irq low during segments", 64'(irqAtStart), 0);
    chk(nObs == nExp, midStart ? "R9 segment count with ignored start" :
        "R7 issued segments (zero counts skipped)", 64'(nObs), 64'(nExp));
    chk(fetchIdx == n - 1, "R5 descriptor fetches", 64'(fetchIdx), 64'(n - 1));
    for (int i = 0; i < nExp && i < nObs && i < 8; i++) begin
      chk(obsLocal[i] == expLocal[i], i == 0 ? "R2 local" : "R4 local",
          64'(obsLocal[i]), 64'(expLocal[i]));
      chk(obsHost[i] == expHost[i], i == 0 ? "R2 host" : "R4 host",
          obsHost[i], expHost[i]);
      chk(obsCount[i] == expCount[i], i == 0 ? "R2 count" : "R4 count",
          64'(obsCount[i]), 64'(expCount[i]));
    end
    pulse(clearReq);
    chk(busy == 1'b0 && chainDoneIrq == 1'b0, "R10 clear to idle",
        {62'b0, busy, chainDoneIrq}, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) hostMem[i] = 0;
    nExp = 0; nObs = 0; irqRise = 0; irqAtStart = 0; abortPulses = 0;
    fetchIdx = 0; wordCnt = 0; rspWait = 0; engWait = 0;
    for (int i = 0; i < 8; i++) fetchBase[i] = 0;
    tick(4);
    // R1: reset state
    chk(!busy && !chainDoneIrq && !abortedFlag && !segStart && !memReqValid && !segAbort,
        "R1 reset outputs", {58'b0, busy, chainDoneIrq, abortedFlag, segStart, memReqValid, segAbort}, 0);
    #9 rstN = 1'b1;
    tick(2);
    chk(!busy, "R1 idle after reset", 64'(busy), 0);

    runChain(1, 0, 0);          // R5 single segment, other attribute bits random
    runChain(3, 0, 0);          // R3 R4 chained
    runChain(4, 32'b1010, 0);   // R7 zero middle and zero last
    runChain(2, 32'b11, 0);     // R7 every count zero
    runChain(3, 0, 1);          // R9 start while running
    for (int r = 0; r < 20; r++) runChain(1 + int'($urandom % 7), int'($urandom % 128) & ~1, 0);

    // R8: abort while the engine is busy
    clearMon(); engineHold = 1;
    buildChain(2, 0);
    pulse(startReq);
    while (nObs == 0) tick(1);
    pulse(abortReq);
    tick(5);
    chk(abortedFlag && !chainDoneIrq, "R8 aborted in transfer",
        {62'b0, abortedFlag, chainDoneIrq}, 2);
    chk(abortPulses == 1, "R8 engine abort strobe", 64'(abortPulses), 1);
    chk(fetchIdx == 0 && wordCnt == 0, "R8 no fetch after abort", 64'(wordCnt), 0);
    engineHold = 0; engWait = 0;
    pulse(clearReq);
    chk(!busy && !abortedFlag, "R10 clear from aborted", {62'b0, busy, abortedFlag}, 0);

    // R8: abort during descriptor fetch
    clearMon();
    buildChain(3, 0);
    pulse(startReq);
    while (!fetchSeen) tick(1);
    pulse(abortReq);
    tick(30);
    chk(abortedFlag && !chainDoneIrq, "R8 aborted in fetch",
        {62'b0, abortedFlag, chainDoneIrq}, 2);
    chk(nObs == 1, "R8 no segment after abort", 64'(nObs), 1);
    chk(abortPulses == 0, "R8 no engine strobe outside transfer", 64'(abortPulses), 0);
    pulse(clearReq);
    chk(!busy, "R10 idle after clear", 64'(busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule